// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept, judged only by its 48-bit destination address. The receive path hands the address over one byte per cycle, in wire order, with a strobe marking the first byte. The block keeps the address bytes and folds each one into a running CRC-32. Once the sixth byte is in, it issues a single accept or reject pulse.

The decision draws on a small set of control registers. These hold the station address, a 64-bit multicast hash table kept as two 32-bit words, and four mode bits: receive enable, promiscuous, pass-all-multicast and hash enable. Software writes the registers through a simple write-enable port. By convention it clears receive enable while it rewrites the address or hash registers, then sets it again.

Top module: `rx_addr_filter`

## Requirements
- R1: After synchronous reset every register reads as zero, so reception is disabled, the station address is 00:00:00:00:00:00 and `dec_valid`/`dec_accept` are low.
- R2: The station address is stored with wire byte 0 in bits 7:0 of the low register (address 1), byte 3 in bits 31:24, byte 4 in bits 7:0 of the high register (address 2) and byte 5 in bits 15:8. A destination equal to it is accepted. The same bytes in reverse order are not a match.
- R3: The broadcast destination FF:FF:FF:FF:FF:FF is always accepted while reception is enabled.
- R4: With the promiscuous bit (control bit 1) set, every destination is accepted.
- R5: A destination is a group address when bit 0 of its first byte is 1. With pass-all-multicast (control bit 2) set, every group address is accepted. Non-matching individual addresses are still rejected.
- R6: With hash enable (control bit 3) set, a group address is accepted when its table bit is 1. The index is bits 31:26 of a CRC-32: polynomial 0x04C11DB7, start value all ones, each byte fed least significant bit first, MSB-shifted register, no final inversion. Index bit 5 picks the word: 1 is the high word (address 4), 0 is the low word (address 3). Bits 4:0 pick the bit in that word. With hash enable clear, or for individual addresses, the table is not consulted.
- R7: A destination matched by no rule is rejected: `dec_valid` pulses with `dec_accept` low.
- R8: While the receive-enable bit (control bit 0) is clear, `dec_valid` stays low and `dec_accept` stays low.
- R9: `dec_valid` is a one-cycle pulse. It is high in the cycle after the clock edge that samples the sixth address byte, and `dec_accept` is valid in that same cycle.
- R10: A byte with `da_start` high always begins a new address, discarding a partly collected one. Bytes presented after the sixth without a start strobe are ignored and cause no decision.
- R11: A write takes effect at the clock edge that samples `cfg_we`. A write to an address above 4 changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register select: 0 control, 1 station low, 2 station high, 3 hash low, 4 hash high |
| cfg_wdata | input | 32 | Register write data |
| da_valid | input | 1 | Address byte valid |
| da_start | input | 1 | Marks the first address byte |
| da_byte | input | 8 | Address byte, wire order |
| dec_valid | output | 1 | Decision strobe, one cycle |
| dec_accept | output | 1 | Accept when high, qualified by dec_valid |

## Verification
A register write is visible from the next edge on. The decision pulse is due exactly one cycle after the edge that takes in the sixth byte. For every frame, the bench therefore looks at the outputs at three falling edges: the one just after the last byte, where `dec_valid` must still be low; the next one, where it must be high with the expected accept bit; and the one after that, where it must be low again. For the disabled, stray-byte and restart cases, the same three-edge window confirms that no pulse appears, or that only one does.

// File: rtl/rxf_pkg.sv
`timescale 1ns/1ps
package rxf_pkg;
    localparam int CFG_AW     = 3;
    localparam int WORD_W     = 32;
    localparam int HASH_BITS  = 6;
    localparam int HASH_SIZE  = 1 << HASH_BITS;
    localparam int STA_HI_W   = 16;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;

    localparam logic [CFG_AW-1:0] REG_CTRL    = 3'd0;
    localparam logic [CFG_AW-1:0] REG_STA_LO  = 3'd1;
    localparam logic [CFG_AW-1:0] REG_STA_HI  = 3'd2;
    localparam logic [CFG_AW-1:0] REG_HASH_LO = 3'd3;
    localparam logic [CFG_AW-1:0] REG_HASH_HI = 3'd4;

    typedef struct packed {
        logic hash_en;
        logic all_multi;
        logic promisc;
        logic rx_en;
    } rxf_ctrl_t;

    typedef enum logic [1:0] {
        MATCH_NONE,
        MATCH_INDIV,
        MATCH_GROUP,
        MATCH_BCAST
    } rxf_kind_e;

    function automatic logic [31:0] crc32_be_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[31] ^ b[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [HASH_BITS-1:0] hash_index(input logic [31:0] c);
        return c[31 -: HASH_BITS];
    endfunction
endpackage

// File: rtl/rxf_regs.sv
`timescale 1ns/1ps
module rxf_regs
    import rxf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output rxf_ctrl_t            ctrl,
    output logic [47:0]          sta_addr,
    output logic [HASH_SIZE-1:0] hash_tbl
);
    localparam int NWORDS = HASH_SIZE / WORD_W;

    logic [WORD_W-1:0]   sta_lo_q;
    logic [STA_HI_W-1:0] sta_hi_q;
    logic [WORD_W-1:0]   hash_q [NWORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            sta_lo_q <= '0;
            sta_hi_q <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_CTRL:   ctrl     <= rxf_ctrl_t'(cfg_wdata[3:0]);
                REG_STA_LO: sta_lo_q <= cfg_wdata;
                REG_STA_HI: sta_hi_q <= cfg_wdata[STA_HI_W-1:0];
                default: ;
            endcase
        end
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_hash
        always_ff @(posedge clk) begin
            if (rst)
                hash_q[w] <= '0;
            else if (cfg_we && cfg_addr == REG_HASH_LO + CFG_AW'(w))
                hash_q[w] <= cfg_wdata;
        end
        assign hash_tbl[w*WORD_W +: WORD_W] = hash_q[w];
    end

    // Wire order: byte 0 occupies the top of sta_addr.
    assign sta_addr = {sta_lo_q[7:0], sta_lo_q[15:8], sta_lo_q[23:16], sta_lo_q[31:24],
                       sta_hi_q[7:0], sta_hi_q[15:8]};

    p_ctrl_write_r11: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == REG_CTRL) |=> (ctrl == rxf_ctrl_t'($past(cfg_wdata[3:0]))));
    p_ctrl_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we && cfg_addr == REG_CTRL) |=> $stable(ctrl));
endmodule

// File: rtl/rxf_collect.sv
`timescale 1ns/1ps
module rxf_collect
    import rxf_pkg::*;
#(
    parameter int NBYTES = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  da_valid,
    input  logic                  da_start,
    input  logic [7:0]            da_byte,
    output logic                  frame_done,
    output logic [NBYTES*8-1:0]   frame_da,
    output logic [31:0]           frame_crc
);
    localparam int AW = NBYTES * 8;
    localparam int CW = $clog2(NBYTES + 1);
    localparam logic [CW-1:0] FULL = CW'(NBYTES);

    logic [CW-1:0] cnt_q;
    logic          take;
    logic [CW-1:0] cnt_nx;

    assign take   = da_valid && (da_start || cnt_q != FULL);
    assign cnt_nx = da_start ? CW'(1) : cnt_q + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= FULL;
            frame_done <= 1'b0;
            frame_da   <= '0;
            frame_crc  <= CRC_INIT;
        end else begin
            frame_done <= take && (cnt_nx == FULL);
            if (take) begin
                cnt_q <= cnt_nx;
                if (da_start) begin
                    frame_da  <= {{(AW-8){1'b0}}, da_byte};
                    frame_crc <= crc32_be_byte(CRC_INIT, da_byte);
                end else begin
                    frame_da  <= {frame_da[AW-9:0], da_byte};
                    frame_crc <= crc32_be_byte(frame_crc, da_byte);
                end
            end
        end
    end

    p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst) cnt_q <= FULL);
    p_done_needs_byte_r9: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(da_valid));
    p_stray_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == FULL && da_valid && !da_start) |=> (!frame_done && $stable(frame_da)));
endmodule

// File: rtl/rxf_decide.sv
`timescale 1ns/1ps
module rxf_decide
    import rxf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  rxf_ctrl_t            ctrl,
    input  logic [47:0]          sta_addr,
    input  logic [HASH_SIZE-1:0] hash_tbl,
    input  logic                 frame_done,
    input  logic [47:0]          frame_da,
    input  logic [31:0]          frame_crc,
    output logic                 dec_valid,
    output logic                 dec_accept
);
    rxf_kind_e            kind;
    logic [HASH_BITS-1:0] idx;
    logic                 hash_hit;
    logic                 accept_c;

    always_comb begin
        if (frame_da == '1)              kind = MATCH_BCAST;
        else if (frame_da == sta_addr)   kind = MATCH_INDIV;
        else if (frame_da[40])           kind = MATCH_GROUP;
        else                             kind = MATCH_NONE;
    end

    assign idx      = hash_index(frame_crc);
    assign hash_hit = ctrl.hash_en && hash_tbl[idx];

    always_comb begin
        accept_c = ctrl.promisc;
        case (kind)
            MATCH_BCAST: accept_c = 1'b1;
            MATCH_INDIV: accept_c = 1'b1;
            MATCH_GROUP: accept_c = accept_c | ctrl.all_multi | hash_hit;
            default:     ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= frame_done && ctrl.rx_en;
            dec_accept <= frame_done && ctrl.rx_en && accept_c;
        end
    end

    p_off_silent_r8: assert property (@(posedge clk) disable iff (rst)
        !ctrl.rx_en |=> (!dec_valid && !dec_accept));
    p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);
    p_promisc_accept_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ctrl.rx_en && ctrl.promisc) |=> dec_accept);
    p_bcast_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (frame_done && ctrl.rx_en && frame_da == '1) |=> dec_accept);
    p_accept_qualified_r9: assert property (@(posedge clk) disable iff (rst)
        dec_accept |-> dec_valid);
endmodule

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter
    import rxf_pkg::*;
#(
    parameter int NBYTES = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              da_valid,
    input  logic              da_start,
    input  logic [7:0]        da_byte,
    output logic              dec_valid,
    output logic              dec_accept
);
    localparam int AW = NBYTES * 8;

    rxf_ctrl_t            ctrl;
    logic [47:0]          sta_addr;
    logic [HASH_SIZE-1:0] hash_tbl;
    logic                 frame_done;
    logic [AW-1:0]        frame_da;
    logic [31:0]          frame_crc;

    rxf_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl),
        .sta_addr  (sta_addr),
        .hash_tbl  (hash_tbl)
    );

    rxf_collect #(.NBYTES(NBYTES)) u_collect (
        .clk        (clk),
        .rst        (rst),
        .da_valid   (da_valid),
        .da_start   (da_start),
        .da_byte    (da_byte),
        .frame_done (frame_done),
        .frame_da   (frame_da),
        .frame_crc  (frame_crc)
    );

    rxf_decide u_decide (
        .clk        (clk),
        .rst        (rst),
        .ctrl       (ctrl),
        .sta_addr   (sta_addr),
        .hash_tbl   (hash_tbl),
        .frame_done (frame_done),
        .frame_da   (frame_da[47:0]),
        .frame_crc  (frame_crc),
        .dec_valid  (dec_valid),
        .dec_accept (dec_accept)
    );
endmodule

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/1ps
module rx_addr_filter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        da_valid = 1'b0;
    logic        da_start = 1'b0;
    logic [7:0]  da_byte = '0;
    logic        dec_valid;
    logic        dec_accept;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .da_valid(da_valid), .da_start(da_start), .da_byte(da_byte),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    localparam logic [47:0] STA = 48'h02_11_22_33_44_55;
    localparam logic [47:0] OTH = 48'h0A_BB_CC_DD_EE_FF;
    localparam logic [47:0] MC  = 48'h01_00_5E_00_00_01;
    localparam logic [47:0] BC  = 48'hFF_FF_FF_FF_FF_FF;
    localparam logic [47:0] REV = 48'h55_44_33_22_11_02;

    // {ctrl[3:0], hash fill, expected accept, pad, destination}
    localparam int NV = 11;
    localparam logic [63:0] VEC [NV] = '{
        {4'h1, 1'b0, 1'b1, 10'd0, STA},            // R2 station match
        {4'h1, 1'b0, 1'b0, 10'd0, 48'h021122334456}, // R7 near miss
        {4'h1, 1'b0, 1'b1, 10'd0, BC},             // R3 broadcast
        {4'h3, 1'b0, 1'b1, 10'd0, OTH},            // R4 promiscuous
        {4'h5, 1'b0, 1'b1, 10'd0, MC},             // R5 all multicast
        {4'h5, 1'b0, 1'b0, 10'd0, OTH},            // R5 individual still rejected
        {4'h9, 1'b1, 1'b1, 10'd0, MC},             // R6 table full
        {4'h9, 1'b0, 1'b0, 10'd0, MC},             // R6 table empty
        {4'h1, 1'b1, 1'b0, 10'd0, MC},             // R6 hash disabled
        {4'h9, 1'b1, 1'b0, 10'd0, OTH},            // R6 individual not hashed
        {4'h1, 1'b0, 1'b0, 10'd0, REV}             // R2 byte order
    };

    function automatic string vreq(input int i);
        case (i)
            0, 10:       return "R2";
            1:           return "R7";
            2:           return "R3";
            3:           return "R4";
            4, 5:        return "R5";
            default:     return "R6";
        endcase
    endfunction

    // Bit-serial reference over the 48 address bits in wire order.
    function automatic logic [31:0] ref_crc(input logic [47:0] da);
        logic [31:0] c;
        logic        d;
        c = 32'hFFFF_FFFF;
        for (int j = 0; j < 48; j++) begin
            d = da[40 - 8*(j/8) + (j%8)];
            c = (c[31] ^ d) ? ({c[30:0], 1'b0} ^ 32'h04C1_1DB7) : {c[30:0], 1'b0};
        end
        return c;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_bytes(input logic [47:0] da, input int n, input bit with_start);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            da_valid = 1'b1;
            da_start = with_start && (i == 0);
            da_byte  = da[47 - 8*i -: 8];
        end
        @(negedge clk);
        da_valid = 1'b0; da_start = 1'b0;
    endtask

    // Called half a cycle after the edge that took the last byte.
    task automatic expect_dec(input string req, input bit exp_v, input bit exp_a);
        chk(req, "valid before due", {31'd0, dec_valid}, 32'd0);
        @(negedge clk);
        chk(req, "valid when due", {31'd0, dec_valid}, {31'd0, exp_v});
        chk(req, "accept when due", {31'd0, dec_accept}, {31'd0, exp_v & exp_a});
        @(negedge clk);
        chk(req, "valid after pulse", {31'd0, dec_valid}, 32'd0);
    endtask

    task automatic set_hash(input logic [31:0] lo, input logic [31:0] hi, input logic [3:0] ctl);
        wr(3'd0, 32'd0);
        wr(3'd3, lo);
        wr(3'd4, hi);
        wr(3'd0, {28'd0, ctl});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] c;
        logic [5:0]  idx;
        logic [31:0] bitw;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "valid after reset", {31'd0, dec_valid}, 32'd0);
        chk("R1", "accept after reset", {31'd0, dec_accept}, 32'd0);
        send_bytes(48'd0, 6, 1'b1);
        expect_dec("R1", 1'b0, 1'b0);           // reception off after reset
        wr(3'd0, 32'h1);
        send_bytes(48'd0, 6, 1'b1);
        expect_dec("R1", 1'b1, 1'b1);           // station reset to zero

        // R2 program station address in little-endian layout
        wr(3'd0, 32'h0);
        wr(3'd1, 32'h33_22_11_02);
        wr(3'd2, 32'h0000_5544);

        // Table-driven main function
        for (int v = 0; v < NV; v++) begin
            set_hash(VEC[v][59] ? 32'hFFFF_FFFF : 32'd0,
                     VEC[v][59] ? 32'hFFFF_FFFF : 32'd0, VEC[v][63:60]);
            send_bytes(VEC[v][47:0], 6, 1'b1);
            expect_dec(vreq(v), 1'b1, VEC[v][58]);
        end

        // R6 single table bit, word select and bit select
        c    = ref_crc(MC);
        idx  = c[31:26];
        bitw = 32'd1 << idx[4:0];
        set_hash(idx[5] ? 32'd0 : bitw, idx[5] ? bitw : 32'd0, 4'h9);
        send_bytes(MC, 6, 1'b1);
        expect_dec("R6", 1'b1, 1'b1);
        set_hash(idx[5] ? bitw : 32'd0, idx[5] ? 32'd0 : bitw, 4'h9);
        send_bytes(MC, 6, 1'b1);
        expect_dec("R6", 1'b1, 1'b0);           // wrong word
        bitw = 32'd1 << (idx[4:0] ^ 5'd1);
        set_hash(idx[5] ? 32'd0 : bitw, idx[5] ? bitw : 32'd0, 4'h9);
        send_bytes(MC, 6, 1'b1);
        expect_dec("R6", 1'b1, 1'b0);           // neighbouring bit

        // R8 reception disabled, even in promiscuous mode
        wr(3'd0, 32'h2);
        send_bytes(STA, 6, 1'b1);
        expect_dec("R8", 1'b0, 1'b0);

        // R11 write to an unused address leaves control untouched
        wr(3'd0, 32'h1);
        wr(3'd7, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        send_bytes(OTH, 6, 1'b1);
        expect_dec("R11", 1'b1, 1'b0);
        send_bytes(STA, 6, 1'b1);
        expect_dec("R11", 1'b1, 1'b1);

        // R10 stray bytes after a completed address
        send_bytes(STA, 4, 1'b0);
        expect_dec("R10", 1'b0, 1'b0);
        // R10 restart mid-address: partial other, then full station
        send_bytes(OTH, 3, 1'b1);
        send_bytes(STA, 6, 1'b1);
        expect_dec("R10", 1'b1, 1'b1);

        // R9 back-to-back addresses each give one pulse
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            da_valid = 1'b1; da_start = (i == 0); da_byte = BC[47 - 8*i -: 8];
        end
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 1) begin
                chk("R9", "first pulse", {31'd0, dec_valid}, 32'd1);
                chk("R9", "first accept", {31'd0, dec_accept}, 32'd1);
            end else begin
                chk("R9", "no pulse mid address", {31'd0, dec_valid}, 32'd0);
            end
            da_valid = 1'b1; da_start = (i == 0); da_byte = OTH[47 - 8*i -: 8];
        end
        @(negedge clk);
        da_valid = 1'b0; da_start = 1'b0;
        expect_dec("R9", 1'b1, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule